// File: doc/BRIEF.md
# Multicore Wait-for-Event Wake and Standby Hub

The hub sits between a cluster of processor cores and the rest of the system and carries the event-based low-power signalling. When any core reports that it has executed a send-event instruction, the hub raises a system-wide event output for a fixed stretch of cycles. It gathers wake-up causes from outside the cluster: an external event line and the rising edge of a request to clear the external exclusive monitor. It sends each wake-up as a single-cycle pulse to every enabled core that waits in the wait-for-event state.

Each core has a standby flag for the wait-for-event state, kept by the hub, and a flag for the wait-for-interrupt state, registered from the core. A wake-up that reaches an enabled core that is not waiting is remembered. That core's next wait-for-event entry then finishes at once. A shared L2 standby flag is raised only when the whole cluster is quiet. The monitor-clear request gets a four-phase acknowledge. All outputs come from registers, and a synchronous active-high reset clears them.

Top module: `wfe_event_hub`

## Requirements
- R1: A send-event pulse on any bit of `sev_i`, sampled at a clock edge, drives `event_o` HIGH for exactly STRETCH cycles (default 3), starting right after that edge.
- R2: A send-event sampled while `event_o` is already HIGH restarts the count, so `event_o` stays HIGH for STRETCH cycles after the latest one.
- R3: `ext_event_i` HIGH at an edge makes `wake_o[i]` a one-cycle pulse after that edge for every enabled core i whose `standby_wfe_o[i]` is 1. That core's `standby_wfe_o[i]` reads 0 one cycle after the pulse.
- R4: A rising edge of `mon_clr_req_i` wakes cores exactly as R3 does. Holding the request HIGH does not wake them again.
- R5: `mon_clr_ack_o` goes HIGH one cycle after `mon_clr_req_i` is first sampled HIGH. It stays HIGH while the request stays HIGH and goes LOW one cycle after the request is sampled LOW.
- R6: A wake cause that reaches an enabled core with `standby_wfe_o[i]` = 0 is latched for that core. The core's next `wfe_enter_i[i]` pulse then leaves `standby_wfe_o[i]` at 0 and clears the latch. A later entry does set the flag.
- R7: A core with `core_en_i[i]` = 0 ignores wake causes. It gets no `wake_o` pulse, it stays in standby, and no event is latched for it.
- R8: `wfe_enter_i[i]` sampled HIGH with no latched or coincident event sets `standby_wfe_o[i]` to 1 after that edge.
- R9: `standby_wfi_o` equals `core_wfi_i` delayed by one cycle.
- R10: `l2_standby_o` is 1 one cycle after an edge at which all of the following hold: every bit of `core_wfi_i` is 1, `l2_idle_i` is 1, and either `mst_inactive_i` is 1 or both `slv_inactive_a_i` and `slv_inactive_b_i` are 1. Otherwise it is 0.
- R11: While `rst` is HIGH, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sev_i | input | N_CORES | Per-core send-event executed pulse |
| wfe_enter_i | input | N_CORES | Per-core wait-for-event entry pulse |
| core_wfi_i | input | N_CORES | Per-core wait-for-interrupt level |
| core_en_i | input | N_CORES | Per-core participation enable |
| ext_event_i | input | 1 | External wake event, each HIGH cycle is one event |
| mon_clr_req_i | input | 1 | Exclusive monitor clear request |
| l2_idle_i | input | 1 | L2 memory system idle |
| mst_inactive_i | input | 1 | Interconnect master side inactive |
| slv_inactive_a_i | input | 1 | Interconnect slave side inactive, first half |
| slv_inactive_b_i | input | 1 | Interconnect slave side inactive, second half |
| event_o | output | 1 | Stretched send-event output |
| wake_o | output | N_CORES | Per-core wake-up pulse |
| standby_wfe_o | output | N_CORES | Per-core wait-for-event standby flag |
| standby_wfi_o | output | N_CORES | Per-core wait-for-interrupt standby flag |
| l2_standby_o | output | 1 | L2 standby flag |
| mon_clr_ack_o | output | 1 | Exclusive monitor clear acknowledge |

## Verification
The properties take for granted that `wfe_enter_i` comes from a core that is not already in standby. They also assume the monitor-clear request follows the four-phase rule: it is raised only while the acknowledge is low and is held until the acknowledge rises. The stimulus gives every entry and event as a single-cycle pulse and holds the request for several cycles. Between scenarios it consumes any wake-up the hub has latched, so that each expected standby value depends only on the current scenario.

// File: rtl/wfe_hub_pkg.sv
package wfe_hub_pkg;

  typedef struct packed {
    logic l2_idle;
    logic mst_inactive;
    logic slv_inactive_a;
    logic slv_inactive_b;
  } idle_t;

  function automatic logic fabric_quiet(idle_t s);
    return s.l2_idle & (s.mst_inactive | (s.slv_inactive_a & s.slv_inactive_b));
  endfunction

endpackage

// File: rtl/event_stretcher.sv
module event_stretcher #(
  parameter int STRETCH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(STRETCH + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (trig_i) begin
      cnt_q <= CW'(STRETCH);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/clr_handshake.sv
module clr_handshake (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic ack_o,
  output logic rise_o
);
  always_ff @(posedge clk) begin
    if (rst) ack_o <= 1'b0;
    else     ack_o <= req_i;
  end

  assign rise_o = req_i & ~ack_o;
endmodule

// File: rtl/core_wake_slice.sv
module core_wake_slice (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic ev_i,
  input  logic enter_i,
  output logic wake_o,
  output logic standby_o
);
  logic pend_q;
  logic hit;

  assign hit = ev_i & en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_o    <= 1'b0;
      standby_o <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      wake_o <= 1'b0;
      if (standby_o) begin
        if (wake_o) begin
          standby_o <= 1'b0;
          if (hit) pend_q <= 1'b1;
        end else if (hit) begin
          wake_o <= 1'b1;
        end
      end else if (enter_i) begin
        if (pend_q || hit) pend_q    <= 1'b0;
        else               standby_o <= 1'b1;
      end else if (hit) begin
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/l2_standby_gate.sv
module l2_standby_gate
  import wfe_hub_pkg::*;
#(
  parameter int N_CORES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CORES-1:0] wfi_i,
  input  idle_t              idle_i,
  output logic [N_CORES-1:0] wfi_q_o,
  output logic               l2_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wfi_q_o <= '0;
      l2_o    <= 1'b0;
    end else begin
      wfi_q_o <= wfi_i;
      l2_o    <= (&wfi_i) & fabric_quiet(idle_i);
    end
  end
endmodule

// File: rtl/wfe_event_hub.sv
module wfe_event_hub
  import wfe_hub_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int STRETCH = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CORES-1:0] sev_i,
  input  logic [N_CORES-1:0] wfe_enter_i,
  input  logic [N_CORES-1:0] core_wfi_i,
  input  logic [N_CORES-1:0] core_en_i,
  input  logic               ext_event_i,
  input  logic               mon_clr_req_i,
  input  logic               l2_idle_i,
  input  logic               mst_inactive_i,
  input  logic               slv_inactive_a_i,
  input  logic               slv_inactive_b_i,
  output logic               event_o,
  output logic [N_CORES-1:0] wake_o,
  output logic [N_CORES-1:0] standby_wfe_o,
  output logic [N_CORES-1:0] standby_wfi_o,
  output logic               l2_standby_o,
  output logic               mon_clr_ack_o
);
  logic  clr_rise;
  logic  wake_cause;
  idle_t idle;

  event_stretcher #(.STRETCH(STRETCH)) u_stretch (
    .clk(clk), .rst(rst), .trig_i(|sev_i), .pulse_o(event_o)
  );

  clr_handshake u_hs (
    .clk(clk), .rst(rst), .req_i(mon_clr_req_i),
    .ack_o(mon_clr_ack_o), .rise_o(clr_rise)
  );

  assign wake_cause = ext_event_i | clr_rise;

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    core_wake_slice u_slice (
      .clk(clk), .rst(rst), .en_i(core_en_i[g]), .ev_i(wake_cause),
      .enter_i(wfe_enter_i[g]), .wake_o(wake_o[g]), .standby_o(standby_wfe_o[g])
    );
  end

  assign idle = '{l2_idle: l2_idle_i, mst_inactive: mst_inactive_i,
                  slv_inactive_a: slv_inactive_a_i, slv_inactive_b: slv_inactive_b_i};

  l2_standby_gate #(.N_CORES(N_CORES)) u_l2 (
    .clk(clk), .rst(rst), .wfi_i(core_wfi_i), .idle_i(idle),
    .wfi_q_o(standby_wfi_o), .l2_o(l2_standby_o)
  );
endmodule

// File: rtl/wfe_event_hub_chk.sv
module wfe_event_hub_chk #(
  parameter int N_CORES = 4,
  parameter int STRETCH = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [N_CORES-1:0] sev_i,
  input logic [N_CORES-1:0] core_en_i,
  input logic               mon_clr_req_i,
  input logic               event_o,
  input logic [N_CORES-1:0] wake_o,
  input logic [N_CORES-1:0] standby_wfe_o,
  input logic [N_CORES-1:0] standby_wfi_o,
  input logic               l2_standby_o,
  input logic               mon_clr_ack_o
);
  localparam int GW = $clog2(STRETCH + 2);
  localparam logic [GW-1:0] GMAX = GW'(STRETCH + 1);

  logic [GW-1:0] gap_q;

  // cycles since the last sampled send-event, saturating
  always_ff @(posedge clk) begin
    if (rst)             gap_q <= GMAX;
    else if (|sev_i)     gap_q <= '0;
    else if (gap_q != GMAX) gap_q <= gap_q + 1'b1;
  end

  // R1 and R2: output width follows the latest send-event
  p_event_len_r1: assert property (@(posedge clk) disable iff (rst)
    event_o == (gap_q < GW'(STRETCH)));

  // R3: a wake pulse only goes to a waiting core
  p_wake_in_standby_r3: assert property (@(posedge clk) disable iff (rst)
    (wake_o & ~standby_wfe_o) == '0);

  // R3: standby drops right after the wake pulse
  p_wake_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (|wake_o) |=> ((standby_wfe_o & $past(wake_o)) == '0));

  // R3: wake is a single-cycle pulse
  p_wake_single_r3: assert property (@(posedge clk) disable iff (rst)
    (|wake_o) |=> ((wake_o & $past(wake_o)) == '0));

  // R7: disabled cores get no wake pulse
  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (wake_o & ~$past(core_en_i)) == '0);

  // R5: acknowledge rises after request, falls after it drops
  p_ack_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mon_clr_req_i) |=> mon_clr_ack_o);
  p_ack_fall_r5: assert property (@(posedge clk) disable iff (rst)
    !mon_clr_req_i |=> !mon_clr_ack_o);

  // R10: L2 standby implies every core in WFI
  p_l2_needs_wfi_r10: assert property (@(posedge clk) disable iff (rst)
    l2_standby_o |-> (&standby_wfi_o));
endmodule

bind wfe_event_hub wfe_event_hub_chk #(.N_CORES(N_CORES), .STRETCH(STRETCH)) u_chk (
  .clk(clk), .rst(rst), .sev_i(sev_i), .core_en_i(core_en_i),
  .mon_clr_req_i(mon_clr_req_i), .event_o(event_o), .wake_o(wake_o),
  .standby_wfe_o(standby_wfe_o), .standby_wfi_o(standby_wfi_o),
  .l2_standby_o(l2_standby_o), .mon_clr_ack_o(mon_clr_ack_o)
);

// File: tb/test_wfe_event_hub.sv
module test_wfe_event_hub;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] sev = '0, enter = '0, wfi = '0, en = '0;
  logic ext = 0, req = 0, l2idle = 0, mst = 0, sa = 0, sb = 0;
  logic event_o, l2_standby_o, ack;
  logic [N-1:0] wake, swfe, swfi;

  wfe_event_hub #(.N_CORES(N), .STRETCH(3)) i_wfe_event_hub (
    .clk(clk), .rst(rst), .sev_i(sev), .wfe_enter_i(enter), .core_wfi_i(wfi),
    .core_en_i(en), .ext_event_i(ext), .mon_clr_req_i(req), .l2_idle_i(l2idle),
    .mst_inactive_i(mst), .slv_inactive_a_i(sa), .slv_inactive_b_i(sb),
    .event_o(event_o), .wake_o(wake), .standby_wfe_o(swfe), .standby_wfi_o(swfi),
    .l2_standby_o(l2_standby_o), .mon_clr_ack_o(ack)
  );

  always #10 clk = ~clk;

  typedef enum int {S_EV, S_WAKE, S_SWFE, S_SWFI, S_L2, S_ACK} sel_e;
  typedef struct {
    int       cyc;
    sel_e     sel;
    logic [7:0] val;
    string    tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] observe(sel_e s);
    case (s)
      S_EV:    return {7'd0, event_o};
      S_WAKE:  return {4'd0, wake};
      S_SWFE:  return {4'd0, swfe};
      S_SWFI:  return {4'd0, swfi};
      S_L2:    return {7'd0, l2_standby_o};
      default: return {7'd0, ack};
    endcase
  endfunction

  task automatic expect_at(int off, sel_e s, logic [7:0] v, string tag);
    item_t it;
    it.cyc = cyc + off; it.sel = s; it.val = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic nxt(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare items due in this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        checks++;
        if (observe(q[i].sel) !== q[i].val) begin
          fails++;
          $display("FAIL %s: %s actual=%h expected=%h at cycle %0d",
                   q[i].tag, q[i].sel.name(), observe(q[i].sel), q[i].val, cyc);
        end
        q.delete(i);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    nxt(1);
    // R11: outputs low during reset
    expect_at(1, S_EV, 0, "R11"); expect_at(1, S_WAKE, 0, "R11");
    expect_at(1, S_SWFE, 0, "R11"); expect_at(1, S_SWFI, 0, "R11");
    expect_at(1, S_L2, 0, "R11"); expect_at(1, S_ACK, 0, "R11");
    nxt(2); rst = 0; nxt(2);

    // R1: stretch of three
    sev = 4'b0001;
    expect_at(1, S_EV, 1, "R1"); expect_at(2, S_EV, 1, "R1");
    expect_at(3, S_EV, 1, "R1"); expect_at(4, S_EV, 0, "R1");
    nxt(1); sev = '0; nxt(5);

    // R2: restart on second send-event
    sev = 4'b0010; nxt(1); sev = '0; nxt(1); sev = 4'b0100;
    expect_at(1, S_EV, 1, "R2"); expect_at(2, S_EV, 1, "R2");
    expect_at(3, S_EV, 1, "R2"); expect_at(4, S_EV, 0, "R2");
    nxt(1); sev = '0; nxt(5);

    // R8 and R3: all cores wait, external event wakes them
    en = 4'hF; enter = 4'hF;
    expect_at(1, S_SWFE, 8'h0F, "R8");
    nxt(1); enter = '0; nxt(1);
    ext = 1;
    expect_at(1, S_WAKE, 8'h0F, "R3"); expect_at(1, S_SWFE, 8'h0F, "R3");
    expect_at(2, S_WAKE, 8'h00, "R3"); expect_at(2, S_SWFE, 8'h00, "R3");
    nxt(1); ext = 0; nxt(3);

    // R4 and R5: monitor clear wakes cores 0,1, handshake
    enter = 4'b0011; nxt(1); enter = '0; nxt(1);
    req = 1;
    expect_at(1, S_WAKE, 8'h03, "R4"); expect_at(2, S_WAKE, 8'h00, "R4");
    expect_at(2, S_SWFE, 8'h00, "R4");
    expect_at(1, S_ACK, 1, "R5"); expect_at(3, S_ACK, 1, "R5");
    expect_at(4, S_ACK, 0, "R5");
    nxt(3); req = 0; nxt(3);

    // R6: cores 2,3 latched the monitor-clear event
    enter = 4'b1100; expect_at(1, S_SWFE, 8'h00, "R6");
    nxt(1); enter = '0; nxt(1);
    enter = 4'b1100; expect_at(1, S_SWFE, 8'h0C, "R6");
    nxt(1); enter = '0; nxt(1);
    ext = 1;
    expect_at(1, S_WAKE, 8'h0C, "R3"); expect_at(2, S_SWFE, 8'h00, "R3");
    nxt(1); ext = 0; nxt(3);
    // cores 0,1 latched that event: their entry completes at once
    enter = 4'b0011; expect_at(1, S_SWFE, 8'h00, "R6");
    nxt(1); enter = '0; nxt(1);

    // R7: disabled cores ignore events
    en = 4'b0101; enter = 4'hF; expect_at(1, S_SWFE, 8'h0F, "R8");
    nxt(1); enter = '0; nxt(1);
    ext = 1;
    expect_at(1, S_WAKE, 8'h05, "R7"); expect_at(2, S_SWFE, 8'h0A, "R7");
    nxt(1); ext = 0; nxt(2);
    en = 4'b1010; ext = 1;
    expect_at(1, S_WAKE, 8'h0A, "R7"); expect_at(2, S_SWFE, 8'h00, "R7");
    nxt(1); ext = 0; nxt(2);
    // cores 0,2 were disabled at that event: nothing latched
    en = 4'hF; enter = 4'hF; expect_at(1, S_SWFE, 8'h0F, "R7");
    nxt(1); enter = '0; nxt(1);
    ext = 1; expect_at(1, S_WAKE, 8'h0F, "R3");
    nxt(1); ext = 0; nxt(3);

    // R9: WFI flags
    wfi = 4'b1010; expect_at(1, S_SWFI, 8'h0A, "R9");
    nxt(1); wfi = 4'b0101; expect_at(1, S_SWFI, 8'h05, "R9");
    nxt(1);

    // R10: L2 standby conditions
    wfi = 4'hF; l2idle = 1; mst = 1;
    expect_at(1, S_L2, 1, "R10"); expect_at(1, S_SWFI, 8'h0F, "R9");
    nxt(1); mst = 0; sa = 1; expect_at(1, S_L2, 0, "R10");
    nxt(1); sb = 1; expect_at(1, S_L2, 1, "R10");
    nxt(1); l2idle = 0; expect_at(1, S_L2, 0, "R10");
    nxt(1); l2idle = 1; wfi = 4'b0111; expect_at(1, S_L2, 0, "R10");
    nxt(1); wfi = 4'hF; expect_at(1, S_L2, 1, "R10");
    nxt(3);

    while (q.size() != 0) nxt(1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule